// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

A synchronous up-counter, four bits wide by default, that advances on the rising clock edge. It can be preset from a parallel data input through an active-low load. An active-low clear forces it to zero. A compile-time parameter selects whether that clear takes effect at once, without waiting for the clock, or only at the next rising edge.

Two active-high count enables gate counting. The counter advances only when both are high. Only the second enable, `cnt_en_t`, gates the carry output. The carry output goes high while the counter holds its all-ones value. Wider counters are built by chaining stages. Each stage's carry feeds the next stage's `cnt_en_t`, and every stage shares one `cnt_en_p`. The upper stage then advances once for each wrap of the lower stage.

The house reset `rst_n` asserts asynchronously and is released through a two-stage synchronizer. As a result, the counter leaves reset on the second rising edge after `rst_n` goes high.

Top module: `presettable_counter`

## Requirements
- R1: While `rst_n` is low, `count` is 0 and `carry` is low; asserting `rst_n` forces this at once, without a clock edge.
- R2: With `clr_n`, `load_n`, `cnt_en_p` and `cnt_en_t` all high, each rising edge adds one to `count`, and the all-ones value wraps to 0.
- R3: With `clr_n` high and `load_n` low, the next rising edge copies `data_in` into `count`, whatever the enables are. If `load_n` is back high before the edge, that edge does not load.
- R4: With `clr_n` and `load_n` high and either enable low, `count` keeps its value across rising edges.
- R5: With `CLEAR_ASYNC` = 0, a low `clr_n` sets `count` to 0 at the next rising edge and does not change `count` before that edge.
- R6: With `CLEAR_ASYNC` = 1, a low `clr_n` sets `count` to 0 and `carry` low immediately, without a clock edge, and `count` stays 0 while `clr_n` is held low.
- R7: Clear takes priority over load and over both enables.
- R8: `carry` is combinational: it equals `cnt_en_t` AND (`count` is all ones), and it does not depend on `cnt_en_p`.
- R9: In a two-stage chain (the lower stage's carry drives the upper stage's `cnt_en_t`, with one shared `cnt_en_p`), the concatenated 8-bit value counts by one per edge, and the upper nibble advances exactly when the lower nibble wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low house reset, released synchronously inside |
| clr_n | input | 1 | Active-low clear; synchronous or immediate per `CLEAR_ASYNC` |
| load_n | input | 1 | Active-low parallel preset |
| cnt_en_p | input | 1 | Count enable that does not affect the carry |
| cnt_en_t | input | 1 | Count enable that also gates the carry |
| data_in | input | WIDTH | Preset value |
| count | output | WIDTH | Current counter value |
| carry | output | 1 | Terminal-count carry, gated by `cnt_en_t` |

## Verification
Load, count, hold and synchronous clear are due one rising edge after the inputs are applied. The bench applies inputs after a falling edge and samples 1 ns after the next rising edge. At that point the inputs are still held, so `carry` is also read there as a combinational function of the new count and the current `cnt_en_t`. The immediate clear and the house reset are due within the same clock cycle. They are checked a fraction of a nanosecond after the input changes and before any edge. The synchronous clear is also sampled just before its edge to show that `count` has not yet moved.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_INC   = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/cnt_rst_sync.sv
module cnt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/cnt_op_decode.sv
module cnt_op_decode
  import cnt_pkg::*;
(
  input  logic    clr_n,
  input  logic    load_n,
  input  logic    cnt_en_p,
  input  logic    cnt_en_t,
  output cnt_op_e op
);
  // Priority: clear, then load, then count, else hold.
  always_comb begin
    if (!clr_n)                   op = OP_CLEAR;
    else if (!load_n)             op = OP_LOAD;
    else if (cnt_en_p && cnt_en_t) op = OP_INC;
    else                          op = OP_HOLD;
  end
endmodule

// File: rtl/cnt_state_reg.sv
module cnt_state_reg
  import cnt_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter bit CLEAR_ASYNC = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_n,
  input  cnt_op_e          op,
  input  logic [WIDTH-1:0] data_in,
  output logic [WIDTH-1:0] q
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic             arst_n;
  logic [WIDTH-1:0] q_next;
  logic             q_en;

  generate
    if (CLEAR_ASYNC) begin : g_async_clr
      assign arst_n = rst_n & clr_n;
    end else begin : g_sync_clr
      assign arst_n = rst_n;
    end
  endgenerate

  always_comb begin
    q_en   = 1'b1;
    q_next = q;
    unique case (op)
      OP_CLEAR: q_next = '0;
      OP_LOAD:  q_next = data_in;
      OP_INC:   q_next = q + ONE;
      default:  q_en   = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)   q <= '0;
    else if (q_en) q <= q_next;
  end
endmodule

// File: rtl/cnt_carry.sv
module cnt_carry #(
  parameter int WIDTH       = 4,
  parameter bit CLEAR_ASYNC = 1'b0
) (
  input  logic [WIDTH-1:0] q,
  input  logic             cnt_en_t,
  input  logic             clr_n,
  output logic             carry
);
  logic term;
  assign term = &q;

  generate
    if (CLEAR_ASYNC) begin : g_gate_clr
      assign carry = term & cnt_en_t & clr_n;
    end else begin : g_plain
      logic unused_clr;
      assign unused_clr = clr_n;
      assign carry = term & cnt_en_t;
    end
  endgenerate
endmodule

// File: rtl/presettable_counter.sv
module presettable_counter
  import cnt_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter bit CLEAR_ASYNC = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic             cnt_en_p,
  input  logic             cnt_en_t,
  input  logic [WIDTH-1:0] data_in,
  output logic [WIDTH-1:0] count,
  output logic             carry
);
  logic    rst_sync_n;
  cnt_op_e op;

  cnt_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cnt_op_decode u_decode (
    .clr_n    (clr_n),
    .load_n   (load_n),
    .cnt_en_p (cnt_en_p),
    .cnt_en_t (cnt_en_t),
    .op       (op)
  );

  cnt_state_reg #(.WIDTH(WIDTH), .CLEAR_ASYNC(CLEAR_ASYNC)) u_state (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr_n   (clr_n),
    .op      (op),
    .data_in (data_in),
    .q       (count)
  );

  cnt_carry #(.WIDTH(WIDTH), .CLEAR_ASYNC(CLEAR_ASYNC)) u_carry (
    .q        (count),
    .cnt_en_t (cnt_en_t),
    .clr_n    (clr_n),
    .carry    (carry)
  );
endmodule

// File: rtl/presettable_counter_checker.sv
module presettable_counter_checker #(
  parameter int WIDTH       = 4,
  parameter bit CLEAR_ASYNC = 1'b0
) (
  input logic             clk,
  input logic             rst_ok,
  input logic             clr_n,
  input logic             load_n,
  input logic             cnt_en_p,
  input logic             cnt_en_t,
  input logic [WIDTH-1:0] data_in,
  input logic [WIDTH-1:0] count,
  input logic             carry
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  assert_count_up_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    (clr_n && load_n && cnt_en_p && cnt_en_t) |=>
      (!clr_n || count == $past(count) + ONE));

  assert_preset_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    (clr_n && !load_n) |=> (!clr_n || count == $past(data_in)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    (clr_n && load_n && !(cnt_en_p && cnt_en_t)) |=>
      (!clr_n || $stable(count)));

  assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    !clr_n |=> (count == '0));

  assert_carry_term_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    carry |-> (cnt_en_t && (&count)));

  assert_carry_rise_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    (cnt_en_t && (&count) && clr_n) |-> carry);

  generate
    if (CLEAR_ASYNC) begin : g_async_chk
      assert_async_zero_R6: assert property (@(posedge clk) disable iff (!rst_ok)
        !clr_n |-> (count == '0 && !carry));
    end
  endgenerate
endmodule

bind presettable_counter presettable_counter_checker #(
  .WIDTH(WIDTH), .CLEAR_ASYNC(CLEAR_ASYNC)
) u_checker (
  .clk      (clk),
  .rst_ok   (rst_sync_n),
  .clr_n    (clr_n),
  .load_n   (load_n),
  .cnt_en_p (cnt_en_p),
  .cnt_en_t (cnt_en_t),
  .data_in  (data_in),
  .count    (count),
  .carry    (carry)
);

// File: tb/test_presettable_counter.sv
`timescale 1ns/100ps
module test_presettable_counter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  // Synchronous-clear unit
  logic       clr_n = 1'b1, load_n = 1'b1, en_p = 1'b0, en_t = 1'b0;
  logic [3:0] d = '0, q;
  logic       co;

  presettable_counter #(.WIDTH(4), .CLEAR_ASYNC(1'b0)) i_presettable_counter (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .load_n(load_n),
    .cnt_en_p(en_p), .cnt_en_t(en_t), .data_in(d), .count(q), .carry(co));

  // Immediate-clear unit
  logic       a_clr_n = 1'b1, a_load_n = 1'b1, a_en_p = 1'b0, a_en_t = 1'b0;
  logic [3:0] a_d = '0, a_q;
  logic       a_co;

  presettable_counter #(.WIDTH(4), .CLEAR_ASYNC(1'b1)) i_async_counter (
    .clk(clk), .rst_n(rst_n), .clr_n(a_clr_n), .load_n(a_load_n),
    .cnt_en_p(a_en_p), .cnt_en_t(a_en_t), .data_in(a_d), .count(a_q), .carry(a_co));

  // Two-stage chain
  logic       c_clr_n = 1'b1, c_load_n = 1'b1, c_en = 1'b0, c_top_t = 1'b1;
  logic [7:0] c_d = '0;
  logic [3:0] lo_q, hi_q;
  logic       lo_co, hi_co;

  presettable_counter #(.WIDTH(4), .CLEAR_ASYNC(1'b0)) i_chain_lo (
    .clk(clk), .rst_n(rst_n), .clr_n(c_clr_n), .load_n(c_load_n),
    .cnt_en_p(c_en), .cnt_en_t(c_top_t), .data_in(c_d[3:0]), .count(lo_q), .carry(lo_co));

  presettable_counter #(.WIDTH(4), .CLEAR_ASYNC(1'b0)) i_chain_hi (
    .clk(clk), .rst_n(rst_n), .clr_n(c_clr_n), .load_n(c_load_n),
    .cnt_en_p(c_en), .cnt_en_t(lo_co), .data_in(c_d[7:4]), .count(hi_q), .carry(hi_co));

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // {clr_n, load_n, en_p, en_t, data[3:0], exp_count[3:0], exp_carry}
  localparam int NV = 14;
  localparam logic [12:0] VEC [NV] = '{
    {4'b0111, 4'd0,  4'd0,  1'b0},  // R5 clear on edge
    {4'b1011, 4'd12, 4'd12, 1'b0},  // R3 preset twelve
    {4'b1111, 4'd0,  4'd13, 1'b0},  // R2
    {4'b1111, 4'd0,  4'd14, 1'b0},  // R2
    {4'b1111, 4'd0,  4'd15, 1'b1},  // R2 R8 terminal
    {4'b1111, 4'd0,  4'd0,  1'b0},  // R2 wrap
    {4'b1111, 4'd0,  4'd1,  1'b0},  // R2
    {4'b1111, 4'd0,  4'd2,  1'b0},  // R2
    {4'b1101, 4'd0,  4'd2,  1'b0},  // R4 en_p low
    {4'b1110, 4'd0,  4'd2,  1'b0},  // R4 en_t low
    {4'b1000, 4'd15, 4'd15, 1'b0},  // R3 load w/o enables, R8 en_t gates
    {4'b1101, 4'd0,  4'd15, 1'b1},  // R4 hold, R8 carry w/ en_p low
    {4'b0011, 4'd9,  4'd0,  1'b0},  // R7 clear beats load
    {4'b1011, 4'd7,  4'd7,  1'b0}   // R3
  };

  initial begin
    #20000;
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual 0 expected 1 (completion)");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 count", int'(q), 0);
    check("R1 carry", int'(co), 0);
    check("R1 async unit", int'(a_q), 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      {clr_n, load_n, en_p, en_t, d} = VEC[i][12:5];
      @(posedge clk); #1;
      check($sformatf("R2-5,7 vec%0d count", i), int'(q), int'(VEC[i][4:1]));
      check($sformatf("R8 vec%0d carry", i), int'(co), int'(VEC[i][0]));
      @(negedge clk);
    end

    // R5: clear low does nothing until the edge
    clr_n = 1'b0; load_n = 1'b1; en_p = 1'b1; en_t = 1'b1;
    #1;
    check("R5 before edge", int'(q), 7);
    @(posedge clk); #1;
    check("R5 after edge", int'(q), 0);
    @(negedge clk) clr_n = 1'b1;
    // R3: load pulse withdrawn before the edge -> count instead
    load_n = 1'b0; d = 4'd9; #0.5 load_n = 1'b1;
    @(posedge clk); #1;
    check("R3 withdrawn load", int'(q), 1);

    // R1: reset mid-run
    @(negedge clk) begin load_n = 1'b0; d = 4'd5; end
    @(negedge clk) begin load_n = 1'b1; en_p = 1'b0; en_t = 1'b0; end
    check("R3 preset five", int'(q), 5);
    rst_n = 1'b0; #0.5;
    check("R1 immediate", int'(q), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release", int'(q), 0);

    // R6: immediate clear unit
    a_load_n = 1'b0; a_d = 4'd15; a_en_t = 1'b1;
    @(posedge clk); #1;
    check("R6 preload", int'(a_q), 15);
    check("R8 async carry", int'(a_co), 1);
    @(negedge clk) a_load_n = 1'b1;
    #0.5 a_clr_n = 1'b0;
    #0.5;
    check("R6 count immediate", int'(a_q), 0);
    check("R6 carry immediate", int'(a_co), 0);
    a_en_p = 1'b1;
    @(posedge clk); #1;
    check("R6 held low", int'(a_q), 0);
    @(negedge clk) a_clr_n = 1'b1;
    @(posedge clk); #1;
    check("R2 after clear", int'(a_q), 1);

    // R9: two-stage chain, crossing several lower wraps and 0xFF
    @(negedge clk) begin c_load_n = 1'b0; c_d = 8'hEC; end
    @(posedge clk); #1;
    check("R9 preload", int'({hi_q, lo_q}), 'hEC);
    @(negedge clk) begin c_load_n = 1'b1; c_en = 1'b1; end
    for (int k = 1; k <= 40; k++) begin
      @(posedge clk); #1;
      check($sformatf("R9 step%0d", k), int'({hi_q, lo_q}), (8'hEC + k) & 8'hFF);
      check("R9 lower carry", int'(lo_co), int'(lo_q == 4'hF));
    end
    @(negedge clk) c_en = 1'b0;
    @(posedge clk); #1;
    check("R4 chain hold", int'({hi_q, lo_q}), (8'hEC + 40) & 8'hFF);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule